// File: doc/BRIEF.md
# PRBS/QRSS Line Test Pattern Engine

This block produces and checks a maintenance test pattern for a single T1 or E1 line channel. The transmit half emits one pseudo-random bit per transmit clock. The receive half takes one bit per receive clock, locks onto the incoming pattern and counts bit errors once it has locked. The line can be looped back, or a far-end engine can send the pattern.

A single mode input chooses the pattern. With `mode_i` = 0 the pattern is the E1 maximal-length 2^15-1 sequence from x^15+x^14+1. With `mode_i` = 1 it is the T1/J1 2^20-1 quasi-random sequence from x^20+x^17+1, with long zero runs broken up. The generator keeps a 20-bit history register. When the bits in use for the selected mode are all zero, it reloads that register with all ones.

The receive side keeps its own copy of the generator. While hunting, it loads that copy from the received bits. Once locked, the copy runs freely, so one corrupted line bit counts as exactly one error. Errors go into a saturating counter that a strobe clears.

Top module: `test_pattern_engine`

## Requirements
- R1: In mode 0 the history register is all ones after reset. On each transmit clock the registered `tx_bit_o` takes the feedback bit h[14]^h[13], and the register shifts left with that bit entering h[0]. If h[14:0] is zero, the register reloads all ones instead. `tx_bit_o` is 0 after reset.
- R2: In mode 1 the feedback is h[19]^h[16]. `tx_bit_o` is the feedback bit ORed with (h[13:0] == 0), so no transmitted zero run is longer than 14 bits. The register reloads all ones when all 20 bits are zero.
- R3: A received stream of constant zero never raises `sync_o` in either mode.
- R4: `sync_o` is 0 after reset and rises only after 32 consecutive received bits match the local reference. It cannot rise within the first 32 receive clocks after reset.
- R5: While locked, an error opens a 64-bit window that starts with that bit. A 6th error inside the window drops `sync_o`. Errors spaced 13 bits apart never drop it, and errors spaced 12 bits apart drop it at the 6th.
- R6: Each mismatched bit received while `sync_o` is 1 adds exactly one to `err_cnt_o`. Mismatches while hunting add nothing.
- R7: `err_cnt_o` (ERR_W bits) stops at all ones and holds there.
- R8: `err_clr_i` zeroes `err_cnt_o` at the next receive clock. It takes priority over an error counted at the same clock.
- R9: A change of `mode_i` seen by the receive side drops `sync_o` at the next receive clock and restarts the hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Transmit bit clock |
| rx_clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: E1 2^15-1 pattern, 1: T1/J1 2^20-1 quasi-random pattern |
| tx_bit_o | output | 1 | Generated pattern bit |
| rx_bit_i | input | 1 | Received bit to check |
| sync_o | output | 1 | Receive side locked to the pattern |
| err_clr_i | input | 1 | Clear strobe for the error count (receive clock domain) |
| err_cnt_o | output | ERR_W | Saturating count of bit errors while locked |

## Verification
Some properties hold on every clock, and the assertions watch these:
- the transmit zero-run limit in quasi-random mode;
- no lock inside the first 32 receive clocks;
- a mode change always dropping lock;
- the counter frozen while unlocked, never stepping by more than one, holding at saturation and zeroed after a clear.

Other behaviour depends on the whole input history, and only the bench scenarios can show it:
- the exact transmitted sequence in each mode;
- lock acquisition on a looped-back stream;
- the 12-versus-13 bit spacing boundary for loss of lock;
- refusal to lock on an all-zero line;
- exact error totals under random error spacing.

// File: rtl/tpe_pkg.sv
`timescale 1ns/1ps
package tpe_pkg;
  typedef enum logic {MODE_E1 = 1'b0, MODE_T1 = 1'b1} tp_mode_e;

  localparam int HIST_W  = 20;
  localparam int E1_LEN  = 15;
  localparam int E1_TAP  = 14;
  localparam int T1_LEN  = 20;
  localparam int T1_TAP  = 17;
  localparam int RUN_MAX = 14;

  function automatic logic tap_fb(input logic [HIST_W-1:0] h, input tp_mode_e m);
    return (m == MODE_T1) ? (h[T1_LEN-1] ^ h[T1_TAP-1]) : (h[E1_LEN-1] ^ h[E1_TAP-1]);
  endfunction

  function automatic logic act_zero(input logic [HIST_W-1:0] h, input tp_mode_e m);
    logic [HIST_W-1:0] mask;
    mask = (m == MODE_T1) ? {HIST_W{1'b1}} : {{(HIST_W-E1_LEN){1'b0}}, {E1_LEN{1'b1}}};
    return (h & mask) == '0;
  endfunction

  // quasi-random variant breaks zero runs longer than RUN_MAX
  function automatic logic line_bit(input logic [HIST_W-1:0] h, input tp_mode_e m);
    return tap_fb(h, m) | ((m == MODE_T1) && (h[RUN_MAX-1:0] == '0));
  endfunction
endpackage

// File: rtl/tpe_gen.sv
`timescale 1ns/1ps
module tpe_gen
  import tpe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tp_mode_e mode_i,
  output logic     bit_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
      bit_o  <= 1'b0;
    end else begin
      bit_o <= line_bit(hist_q, mode_i);
      if (act_zero(hist_q, mode_i)) hist_q <= '1;
      else hist_q <= {hist_q[HIST_W-2:0], tap_fb(hist_q, mode_i)};
    end
  end
endmodule

// File: rtl/tpe_sync.sv
`timescale 1ns/1ps
module tpe_sync
  import tpe_pkg::*;
#(
  parameter int SYNC_BITS = 32,
  parameter int LOSS_ERRS = 6,
  parameter int WIN_BITS  = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tp_mode_e mode_i,
  input  logic     rx_bit_i,
  output logic     sync_o,
  output logic     err_o
);
  localparam int MC_W = $clog2(SYNC_BITS);
  localparam int WC_W = $clog2(WIN_BITS);
  localparam int WE_W = $clog2(LOSS_ERRS + 1);

  typedef enum logic {ST_HUNT, ST_LOCK} st_e;

  st_e               st_q;
  tp_mode_e          mode_q;
  logic [HIST_W-1:0] ref_q;
  logic [MC_W-1:0]   match_q;
  logic              win_open_q;
  logic [WC_W-1:0]   win_cnt_q;
  logic [WE_W-1:0]   win_err_q;

  logic miss, ref_dead, mode_chg;

  always_comb begin
    miss     = rx_bit_i ^ line_bit(ref_q, mode_i);
    ref_dead = act_zero(ref_q, mode_i);
    mode_chg = (mode_i != mode_q);
  end

  assign sync_o = (st_q == ST_LOCK);
  assign err_o  = (st_q == ST_LOCK) && miss && !mode_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      mode_q     <= MODE_E1;
      ref_q      <= '1;
      match_q    <= '0;
      win_open_q <= 1'b0;
      win_cnt_q  <= '0;
      win_err_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg) begin
        st_q       <= ST_HUNT;
        match_q    <= '0;
        win_open_q <= 1'b0;
        ref_q      <= {ref_q[HIST_W-2:0], rx_bit_i};
      end else begin
        case (st_q)
          ST_HUNT: begin
            ref_q <= {ref_q[HIST_W-2:0], rx_bit_i};
            if (!miss && !ref_dead) begin
              if (match_q == MC_W'(SYNC_BITS - 1)) begin
                st_q       <= ST_LOCK;
                match_q    <= '0;
                win_open_q <= 1'b0;
              end else begin
                match_q <= match_q + MC_W'(1);
              end
            end else begin
              match_q <= '0;
            end
          end
          default: begin
            ref_q <= {ref_q[HIST_W-2:0], tap_fb(ref_q, mode_i)};
            if (!win_open_q) begin
              if (miss) begin
                win_open_q <= 1'b1;
                win_cnt_q  <= WC_W'(1);
                win_err_q  <= WE_W'(1);
              end
            end else if (miss && (win_err_q == WE_W'(LOSS_ERRS - 1))) begin
              st_q       <= ST_HUNT;
              match_q    <= '0;
              win_open_q <= 1'b0;
            end else begin
              if (miss) win_err_q <= win_err_q + WE_W'(1);
              if (win_cnt_q == WC_W'(WIN_BITS - 1)) win_open_q <= 1'b0;
              else win_cnt_q <= win_cnt_q + WC_W'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tpe_err_cnt.sv
`timescale 1ns/1ps
module tpe_err_cnt #(
  parameter int ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i && (cnt_o != {ERR_W{1'b1}})) cnt_o <= cnt_o + ERR_W'(1);
  end
endmodule

// File: rtl/test_pattern_engine.sv
`timescale 1ns/1ps
module test_pattern_engine
  import tpe_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int SYNC_BITS = 32,
  parameter int LOSS_ERRS = 6,
  parameter int WIN_BITS  = 64
) (
  input  logic             tx_clk_i,
  input  logic             rx_clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  output logic             tx_bit_o,
  input  logic             rx_bit_i,
  output logic             sync_o,
  input  logic             err_clr_i,
  output logic [ERR_W-1:0] err_cnt_o
);
  tp_mode_e mode;
  logic     err_pulse;

  assign mode = tp_mode_e'(mode_i);

  tpe_gen u_gen (
    .clk_i  (tx_clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .bit_o  (tx_bit_o)
  );

  tpe_sync #(
    .SYNC_BITS (SYNC_BITS),
    .LOSS_ERRS (LOSS_ERRS),
    .WIN_BITS  (WIN_BITS)
  ) u_sync (
    .clk_i    (rx_clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .rx_bit_i (rx_bit_i),
    .sync_o   (sync_o),
    .err_o    (err_pulse)
  );

  tpe_err_cnt #(.ERR_W(ERR_W)) u_cnt (
    .clk_i  (rx_clk_i),
    .rst_ni (rst_ni),
    .inc_i  (err_pulse),
    .clr_i  (err_clr_i),
    .cnt_o  (err_cnt_o)
  );
endmodule

// File: rtl/tpe_sva.sv
`timescale 1ns/1ps
module tpe_sva
  import tpe_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int SYNC_BITS = 32
) (
  input logic             tx_clk_i,
  input logic             rx_clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             tx_bit_o,
  input logic             sync_o,
  input logic             err_clr_i,
  input logic [ERR_W-1:0] err_cnt_o
);
  localparam int CY_W = $clog2(SYNC_BITS) + 1;

  logic [CY_W-1:0] cyc_q;
  logic            mode_prev_q, mode_vld_q;
  logic [4:0]      zrun_q;
  logic            txm_q;

  always_ff @(posedge rx_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= '0;
      mode_prev_q <= 1'b0;
      mode_vld_q  <= 1'b0;
    end else begin
      if (cyc_q != CY_W'(SYNC_BITS)) cyc_q <= cyc_q + CY_W'(1);
      mode_prev_q <= mode_i;
      mode_vld_q  <= 1'b1;
    end
  end

  always_ff @(posedge tx_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q <= '0;
      txm_q  <= 1'b0;
    end else begin
      txm_q <= mode_i;
      if (!txm_q || tx_bit_o) zrun_q <= '0;
      else if (zrun_q != 5'd31) zrun_q <= zrun_q + 5'd1;
    end
  end

  p_zero_run_r2: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    zrun_q <= 5'(RUN_MAX));

  p_no_early_sync_r4: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (cyc_q < CY_W'(SYNC_BITS)) |-> !sync_o);

  p_hunt_hold_r6: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (!sync_o && !err_clr_i) |=> $stable(err_cnt_o));

  p_step_one_r6: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    !err_clr_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                    (err_cnt_o == $past(err_cnt_o) + ERR_W'(1))));

  p_saturate_r7: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    ((err_cnt_o == {ERR_W{1'b1}}) && !err_clr_i) |=> (err_cnt_o == {ERR_W{1'b1}}));

  p_clear_zero_r8: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    err_clr_i |=> (err_cnt_o == '0));

  p_mode_drop_r9: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (mode_vld_q && (mode_i != mode_prev_q)) |=> !sync_o);
endmodule

bind test_pattern_engine tpe_sva #(
  .ERR_W     (ERR_W),
  .SYNC_BITS (SYNC_BITS)
) u_tpe_sva (
  .tx_clk_i  (tx_clk_i),
  .rx_clk_i  (rx_clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .tx_bit_o  (tx_bit_o),
  .sync_o    (sync_o),
  .err_clr_i (err_clr_i),
  .err_cnt_o (err_cnt_o)
);

// File: tb/test_pattern_engine_tb.sv
`timescale 1ns/1ps
module test_pattern_engine_tb;
  logic clk = 1'b0;
  logic rst_n, mode, flip, zero_rx, clr;
  logic tx, tx_s, rx, sync, sync_s;
  logic [15:0] cnt;
  logic [3:0]  cnt_s;

  int n_chk = 0, n_fail = 0;
  int tx_bad_e1 = 0, tx_bad_t1 = 0, run = 0, run_max = 0;

  always #4 clk = ~clk;

  assign rx = zero_rx ? 1'b0 : (tx ^ flip);

  test_pattern_engine u_dut (
    .tx_clk_i(clk), .rx_clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .tx_bit_o(tx), .rx_bit_i(rx), .sync_o(sync), .err_clr_i(clr), .err_cnt_o(cnt)
  );

  test_pattern_engine #(.ERR_W(4)) u_dut_sat (
    .tx_clk_i(clk), .rx_clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .tx_bit_o(tx_s), .rx_bit_i(rx), .sync_o(sync_s), .err_clr_i(clr), .err_cnt_o(cnt_s)
  );

  // generator model built from R1/R2
  logic [19:0] m_h;
  logic        m_bit, m_mode;

  function automatic logic m_fb(input logic [19:0] h, input logic md);
    return md ? (h[19] ^ h[16]) : (h[14] ^ h[13]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h <= '1; m_bit <= 1'b0; m_mode <= 1'b0;
    end else begin
      m_mode <= mode;
      m_bit  <= m_fb(m_h, mode) | (mode && (m_h[13:0] == 14'd0));
      if ((mode ? m_h : (m_h & 20'h07fff)) == 20'd0) m_h <= '1;
      else m_h <= {m_h[18:0], m_fb(m_h, mode)};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx !== m_bit) begin
        if (m_mode) tx_bad_t1++; else tx_bad_e1++;
      end
      if (!m_mode || tx) run = 0;
      else begin
        run++;
        if (run > run_max) run_max = run;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic inject();
    flip = 1'b1;
    @(negedge clk);
    flip = 1'b0;
  endtask

  task automatic spaced(input int n, input int lo, input int hi);
    for (int i = 0; i < n; i++) begin
      inject();
      if (i < n - 1) tick(int'($urandom_range(hi, lo)) - 1);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; mode = 1'b0; flip = 1'b0; zero_rx = 1'b0; clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    check("R4 reset sync", sync, 0);
    check("R6 reset count", cnt, 0);
    check("R1 reset tx", tx, 0);

    // E1 acquisition
    tick(30);
    check("R4 no early sync", sync, 0);
    tick(100);
    check("R4 E1 lock", sync, 1);

    // random spaced errors, never 6 per window
    spaced(20, 13, 40);
    tick(2);
    check("R5 spaced 13+ keeps lock", sync, 1);
    check("R6 E1 count", cnt, 20);
    check("R7 narrow counter saturates", cnt_s, 15);
    spaced(2, 13, 20);
    tick(2);
    check("R7 narrow counter holds", cnt_s, 15);
    tick(80);

    // clear together with an error
    flip = 1'b1; clr = 1'b1;
    @(negedge clk);
    flip = 1'b0; clr = 1'b0;
    check("R8 clear wins", cnt, 0);
    check("R8 narrow clear", cnt_s, 0);
    tick(80);

    spaced(5, 13, 13);
    tick(2);
    check("R5 five at 13 keep lock", sync, 1);
    check("R6 five counted", cnt, 5);
    tick(80);

    spaced(6, 12, 12);
    check("R5 sixth at 12 drops lock", sync, 0);
    check("R6 six counted", cnt, 11);
    spaced(3, 3, 3);
    tick(1);
    check("R6 hunting errors ignored", cnt, 11);
    tick(150);
    check("R4 E1 relock", sync, 1);
    check("R6 count after relock", cnt, 11);

    // all-zero line, E1
    zero_rx = 1'b1;
    tick(300);
    check("R3 E1 zeros no lock", sync, 0);
    zero_rx = 1'b0;
    pulse_clr();
    tick(150);
    check("R4 E1 lock after zeros", sync, 1);
    check("R6 no spurious count", cnt, 0);

    // switch to T1
    mode = 1'b1;
    tick(1);
    check("R9 mode change drops lock", sync, 0);
    tick(300);
    check("R4 T1 lock", sync, 1);
    pulse_clr();
    tick(2);
    check("R8 plain clear", cnt, 0);
    tick(80);
    spaced(30, 13, 40);
    tick(2);
    check("R6 T1 count", cnt, 30);
    check("R7 T1 narrow saturates", cnt_s, 15);
    check("R5 T1 keeps lock", sync, 1);
    tick(80);
    spaced(6, 12, 12);
    check("R5 T1 sixth at 12 drops", sync, 0);
    check("R6 T1 six counted", cnt, 36);

    // long clean T1 run
    tick(200);
    check("R4 T1 relock", sync, 1);
    tick(60000);
    check("R2 T1 tx sequence", tx_bad_t1, 0);
    check("R2 T1 zero run le 14", (run_max <= 14) ? 1 : 0, 1);
    check("R6 T1 clean run count", cnt, 36);
    check("R4 T1 lock held", sync, 1);

    // all-zero line, T1
    zero_rx = 1'b1;
    tick(300);
    check("R3 T1 zeros no lock", sync, 0);
    zero_rx = 1'b0;
    tick(300);
    check("R4 T1 lock after zeros", sync, 1);

    // back to E1
    mode = 1'b0;
    tick(1);
    check("R9 mode change to E1 drops", sync, 0);
    tick(200);
    check("R4 E1 lock after switch", sync, 1);
    tick(2000);
    check("R1 E1 tx sequence", tx_bad_e1, 0);

    summary();
    $finish;
  end
endmodule